// File: doc/BRIEF.md
# Video Timing Meter

This block measures the timing of an incoming raster video stream. It runs on the pixel clock and observes horizontal sync, vertical sync, a data-enable and an auxiliary-data indicator. From these it derives the horizontal and vertical totals, the sync widths, and the front and back porches. It also reports pixel clocks per frame, the number of auxiliary-data cycles that fall in lines without active video, the number of lines that carry active video, and the number of complete frames seen. Software sets the sync polarity, enables measurement, and can freeze the readable results while it reads them.

Measurement runs continuously. Each result is captured at an active sync edge. A frame's results are committed to the output words one cycle after the frame boundary, unless freeze is high in that cycle. The vertical chain steps once per line, on the horizontal sync leading edge, using the vertical sync level and the presence of data-enable in the line that just ended. Results use offset encodings, so that software can recover the true values with a fixed addition. A separate lock monitor tracks the pixel-clock lock input and raises a sticky interrupt when lock is lost.

Top module: `vid_timing_meter`

## Requirements
- R1: `h_word0` holds the line length in pixel clocks minus one in bits 31:16, and the horizontal sync width in pixel clocks in bits 15:0.
- R2: `h_word1` holds the horizontal front porch (last data-enable cycle to sync start) in bits 31:16, and the horizontal back porch (sync end to first data-enable cycle) minus two in bits 15:0.
- R3: `v_word0` holds the frame length in lines minus one in bits 31:16, and the vertical sync width in lines in bits 15:0.
- R4: `v_word1` holds the vertical front porch in lines minus one in bits 31:16, and the vertical back porch in lines in bits 15:0.
- R5: `pol_sel[0]` selects the active level of hsync and `pol_sel[1]` selects the active level of vsync; 1 means active high and 0 means active low. A stream whose polarities match `pol_sel` gives the same results whatever the polarity.
- R6: `cnt_word` holds, in bits 15:0, the number of lines containing data-enable in the last committed frame. Bits 31:16 hold the number of complete frames since measurement was enabled.
- R7: `pix_frame_m1` is the number of pixel clocks in the last committed frame minus one.
- R8: `vb_data_m1` is the number of `aux_data` cycles in lines without any data-enable in the last committed frame, minus one (modulo 2^32). Auxiliary cycles in active lines are not counted.
- R9: While `meas_en` is low, every result output is zero. After `meas_en` rises, the results stay zero until one complete frame has been measured.
- R10: While `freeze` is high, the result outputs hold their values and measurement continues. After `freeze` falls, the next frame boundary commits fresh results.
- R11: `lock_sts` follows `clk_locked` one cycle later. A fall of lock sets `irq` on the next clock.
- R12: A pulse on `irq_clr` clears `irq`. If lock is lost in the same cycle as a clear, `irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync as received |
| vsync | input | 1 | Vertical sync as received |
| de | input | 1 | Active-video data enable |
| aux_data | input | 1 | Auxiliary-data cycle indicator |
| pol_sel | input | 2 | Sync polarity: bit 0 hsync, bit 1 vsync, 1 = active high |
| meas_en | input | 1 | Measurement enable; low clears, rising restarts |
| freeze | input | 1 | Hold result outputs |
| clk_locked | input | 1 | Pixel-clock lock indication |
| irq_clr | input | 1 | Clear pending interrupt |
| h_word0 | output | 32 | Horizontal total-1 / sync width |
| h_word1 | output | 32 | Horizontal front porch / back porch-2 |
| v_word0 | output | 32 | Vertical total-1 / sync width |
| v_word1 | output | 32 | Vertical front porch-1 / back porch |
| cnt_word | output | 32 | Complete frames / data lines |
| pix_frame_m1 | output | 32 | Pixel clocks per frame minus one |
| vb_data_m1 | output | 32 | Auxiliary cycles in blank lines minus one |
| lock_sts | output | 1 | Registered lock status |
| irq | output | 1 | Sticky lock-loss interrupt |

## Verification
The lock monitor has two functions that can act in the same cycle: a lock-loss event that sets the interrupt and a software clear that resets it. The bench drops `clk_locked` and pulses `irq_clr` on the same clock edge, then expects `irq` to remain set, because the set takes priority. A second collision is between freeze and the one-cycle commit stage at a frame boundary. The bench runs a stream with a different timing while frozen and expects every word to keep the earlier values. After `freeze` is released, it expects the new timing to appear.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
  localparam int SPAN_W = 16;
  localparam int STAT_W = 32;

  typedef struct packed {
    logic [SPAN_W-1:0] tot_m1;
    logic [SPAN_W-1:0] wid;
    logic [SPAN_W-1:0] fp;
    logic [SPAN_W-1:0] bp;
  } span_t;
endpackage

// File: rtl/vtm_span.sv
// One axis of timing: position counter plus edge-captured spans.
// Steps only when step is high (every clock for horizontal, once per line for vertical).
module vtm_span
  import vtm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  step,
  input  logic  sync_act,
  input  logic  act,
  output span_t res,
  output logic  lead
);
  logic              sync_q, act_q, seen, had_act;
  logic [SPAN_W-1:0] pos, act_end;
  logic              trail, arise, afall;

  assign lead  = step & sync_act & ~sync_q;
  assign trail = step & ~sync_act & sync_q;
  assign arise = step & act & ~act_q;
  assign afall = step & ~act & act_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sync_q  <= 1'b0;
      act_q   <= 1'b0;
      seen    <= 1'b0;
      had_act <= 1'b0;
      pos     <= '0;
      act_end <= '0;
      res     <= '0;
    end else if (step) begin
      sync_q <= sync_act;
      act_q  <= act;
      pos    <= lead ? '0 : pos + 1'b1;
      if (lead) begin
        seen    <= 1'b1;
        had_act <= 1'b0;
        if (seen) res.tot_m1 <= pos;
        if (seen && had_act) res.fp <= pos + 1'b1 - act_end;
      end
      if (trail) res.wid <= pos + 1'b1;
      if (arise) begin
        res.bp  <= pos + 1'b1 - res.wid;
        had_act <= 1'b1;
      end
      if (afall) act_end <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/vtm_frame_stats.sv
// Per-frame accumulators captured at each frame boundary.
module vtm_frame_stats #(
  parameter int CNT_W  = 32,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              line_end,
  input  logic              line_had_de,
  input  logic              aux,
  input  logic              frame_lead,
  output logic [CNT_W-1:0]  pix_m1,
  output logic [CNT_W-1:0]  vb_m1,
  output logic [LINE_W-1:0] de_lines,
  output logic [LINE_W-1:0] frames,
  output logic              seen
);
  logic [CNT_W-1:0]  pix_cnt, line_aux, vb_sum;
  logic [LINE_W-1:0] line_sum;
  logic [CNT_W-1:0]  aux_add;
  logic [LINE_W-1:0] de_add;

  assign aux_add = line_had_de ? '0 : line_aux;
  assign de_add  = line_had_de ? LINE_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pix_cnt  <= '0;
      line_aux <= '0;
      vb_sum   <= '0;
      line_sum <= '0;
      pix_m1   <= '0;
      vb_m1    <= '0;
      de_lines <= '0;
      frames   <= '0;
      seen     <= 1'b0;
    end else begin
      pix_cnt  <= frame_lead ? '0 : pix_cnt + 1'b1;
      line_aux <= line_end ? CNT_W'(aux) : line_aux + CNT_W'(aux);
      if (frame_lead) begin
        seen     <= 1'b1;
        pix_m1   <= pix_cnt;
        vb_m1    <= vb_sum + aux_add - 1'b1;
        de_lines <= line_sum + de_add;
        vb_sum   <= '0;
        line_sum <= '0;
        if (seen) frames <= frames + 1'b1;
      end else if (line_end) begin
        vb_sum   <= vb_sum + aux_add;
        line_sum <= line_sum + de_add;
      end
    end
  end
endmodule

// File: rtl/vtm_lock_mon.sv
module vtm_lock_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_locked,
  input  logic irq_clr,
  output logic lock_sts,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_sts <= 1'b0;
      irq      <= 1'b0;
    end else begin
      lock_sts <= clk_locked;
      if (lock_sts && !clk_locked) irq <= 1'b1;
      else if (irq_clr)            irq <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_timing_meter.sv
module vid_timing_meter
  import vtm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ACC_W  = STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              de,
  input  logic              aux_data,
  input  logic [1:0]        pol_sel,
  input  logic              meas_en,
  input  logic              freeze,
  input  logic              clk_locked,
  input  logic              irq_clr,
  output logic [WORD_W-1:0] h_word0,
  output logic [WORD_W-1:0] h_word1,
  output logic [WORD_W-1:0] v_word0,
  output logic [WORD_W-1:0] v_word1,
  output logic [WORD_W-1:0] cnt_word,
  output logic [ACC_W-1:0]  pix_frame_m1,
  output logic [ACC_W-1:0]  vb_data_m1,
  output logic              lock_sts,
  output logic              irq
);
  localparam int HALF_W = WORD_W / 2;

  logic              clr;
  logic              hs_act, vs_act;
  logic              h_lead, v_lead;
  logic              vs_line, line_de;
  logic              commit_pend;
  span_t             h_res, v_res;
  logic [ACC_W-1:0]  st_pix, st_vb;
  logic [HALF_W-1:0] st_lines, st_frames;
  logic              st_seen;

  assign clr    = ~meas_en;
  assign hs_act = pol_sel[0] ? hsync : ~hsync;
  assign vs_act = pol_sel[1] ? vsync : ~vsync;

  // line-level inputs for the vertical axis: describe the line that just ended
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      vs_line <= 1'b0;
      line_de <= 1'b0;
    end else begin
      if (h_lead) begin
        vs_line <= vs_act;
        line_de <= de;
      end else if (de) begin
        line_de <= 1'b1;
      end
    end
  end

  vtm_span u_hspan (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(1'b1),
    .sync_act(hs_act), .act(de), .res(h_res), .lead(h_lead)
  );

  vtm_span u_vspan (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(h_lead),
    .sync_act(vs_line), .act(line_de), .res(v_res), .lead(v_lead)
  );

  vtm_frame_stats #(.CNT_W(ACC_W), .LINE_W(HALF_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .line_end(h_lead), .line_had_de(line_de), .aux(aux_data),
    .frame_lead(v_lead),
    .pix_m1(st_pix), .vb_m1(st_vb), .de_lines(st_lines),
    .frames(st_frames), .seen(st_seen)
  );

  vtm_lock_mon u_lock (
    .clk(clk), .rst_n(rst_n), .clk_locked(clk_locked),
    .irq_clr(irq_clr), .lock_sts(lock_sts), .irq(irq)
  );

  // commit one cycle after a frame boundary so all shadows have settled
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      commit_pend  <= 1'b0;
      h_word0      <= '0;
      h_word1      <= '0;
      v_word0      <= '0;
      v_word1      <= '0;
      cnt_word     <= '0;
      pix_frame_m1 <= '0;
      vb_data_m1   <= '0;
    end else begin
      commit_pend <= v_lead & st_seen;
      if (commit_pend && !freeze) begin
        h_word0      <= {HALF_W'(h_res.tot_m1), HALF_W'(h_res.wid)};
        h_word1      <= {HALF_W'(h_res.fp), HALF_W'(h_res.bp - SPAN_W'(2))};
        v_word0      <= {HALF_W'(v_res.tot_m1), HALF_W'(v_res.wid)};
        v_word1      <= {HALF_W'(v_res.fp - SPAN_W'(1)), HALF_W'(v_res.bp)};
        cnt_word     <= {st_frames, st_lines};
        pix_frame_m1 <= st_pix;
        vb_data_m1   <= st_vb;
      end
    end
  end
endmodule

// File: rtl/vtm_checks.sv
module vtm_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        meas_en,
  input logic        freeze,
  input logic        clk_locked,
  input logic        irq_clr,
  input logic        lock_sts,
  input logic        irq,
  input logic [31:0] h_word0,
  input logic [31:0] v_word1,
  input logic [31:0] pix_frame_m1
);
  AST_IRQ_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_sts && !clk_locked) |=> irq); // R11

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !(lock_sts && !clk_locked)) |=> !irq); // R12

  AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> (h_word0 == 32'd0 && pix_frame_m1 == 32'd0)); // R9

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freeze) && $past(meas_en)) |-> ($stable(h_word0) && $stable(v_word1) && $stable(pix_frame_m1))); // R10
endmodule

bind vid_timing_meter vtm_checks u_checks (
  .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .freeze(freeze),
  .clk_locked(clk_locked), .irq_clr(irq_clr), .lock_sts(lock_sts),
  .irq(irq), .h_word0(h_word0), .v_word1(v_word1),
  .pix_frame_m1(pix_frame_m1)
);

// File: tb/tb_vid_timing_meter.sv
module tb_vid_timing_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsync = 1'b0, vsync = 1'b0, de = 1'b0, aux_data = 1'b0;
  logic [1:0]  pol_sel = 2'b11;
  logic        meas_en = 1'b0, freeze = 1'b0, clk_locked = 1'b1, irq_clr = 1'b0;
  logic [31:0] h_word0, h_word1, v_word0, v_word1, cnt_word, pix_frame_m1, vb_data_m1;
  logic        lock_sts, irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int hsw, hbp, hact, hfp;
    int vsw, vbp, vact, vfp;
  } tim_t;

  localparam int AUX_N = 2;

  vid_timing_meter dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .de(de),
    .aux_data(aux_data), .pol_sel(pol_sel), .meas_en(meas_en),
    .freeze(freeze), .clk_locked(clk_locked), .irq_clr(irq_clr),
    .h_word0(h_word0), .h_word1(h_word1), .v_word0(v_word0),
    .v_word1(v_word1), .cnt_word(cnt_word), .pix_frame_m1(pix_frame_m1),
    .vb_data_m1(vb_data_m1), .lock_sts(lock_sts), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int hlen(tim_t t); return t.hsw + t.hbp + t.hact + t.hfp; endfunction
  function automatic int vlen(tim_t t); return t.vsw + t.vbp + t.vact + t.vfp; endfunction
  function automatic logic [31:0] e_h0(tim_t t); return {16'(hlen(t) - 1), 16'(t.hsw)}; endfunction
  function automatic logic [31:0] e_h1(tim_t t); return {16'(t.hfp), 16'(t.hbp - 2)}; endfunction
  function automatic logic [31:0] e_v0(tim_t t); return {16'(vlen(t) - 1), 16'(t.vsw)}; endfunction
  function automatic logic [31:0] e_v1(tim_t t); return {16'(t.vfp - 1), 16'(t.vbp)}; endfunction
  function automatic logic [31:0] e_pix(tim_t t); return 32'(hlen(t) * vlen(t) - 1); endfunction
  function automatic logic [31:0] e_vb(tim_t t); return 32'((vlen(t) - t.vact) * AUX_N - 1); endfunction

  task automatic drive_line(tim_t t, bit vs, bit act_line);
    int n = hlen(t);
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      hsync    = (p < t.hsw) ? pol_sel[0] : ~pol_sel[0];
      vsync    = vs ? pol_sel[1] : ~pol_sel[1];
      de       = act_line && (p >= t.hsw + t.hbp) && (p < t.hsw + t.hbp + t.hact);
      aux_data = act_line ? (p == n - 1)
                          : ((p >= t.hsw + t.hbp) && (p < t.hsw + t.hbp + AUX_N));
    end
  endtask

  task automatic drive_frames(tim_t t, int nf, bit trailer);
    for (int f = 0; f < nf; f++)
      for (int l = 0; l < vlen(t); l++)
        drive_line(t, l < t.vsw, (l >= t.vsw + t.vbp) && (l < t.vsw + t.vbp + t.vact));
    if (trailer) begin
      drive_line(t, 1'b1, 1'b0);
      drive_line(t, 1'b1, 1'b0);
    end
    idle(4);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hsync = ~pol_sel[0]; vsync = ~pol_sel[1]; de = 1'b0; aux_data = 1'b0;
    end
  endtask

  task automatic restart(logic [1:0] pol);
    @(negedge clk); meas_en = 1'b0; pol_sel = pol;
    idle(3);
    @(negedge clk); meas_en = 1'b1;
  endtask

  tim_t ta = '{hsw:3, hbp:5, hact:20, hfp:4, vsw:2, vbp:3, vact:6, vfp:2};
  tim_t tb = '{hsw:4, hbp:6, hact:16, hfp:2, vsw:1, vbp:2, vact:5, vfp:3};

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9 reset h_word0", h_word0, 32'd0);
    chk("R9 reset pix", pix_frame_m1, 32'd0);
    chk("R11 reset lock_sts", 32'(lock_sts), 32'd0);
    chk("R12 reset irq", 32'(irq), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 lock_sts follows lock", 32'(lock_sts), 32'd1);
  endtask

  task automatic t_partial;
    restart(2'b11);
    drive_frames(ta, 1, 1'b0);
    chk("R9 zero before full frame h_word0", h_word0, 32'd0);
    chk("R9 zero before full frame cnt", cnt_word, 32'd0);
  endtask

  task automatic t_basic;
    restart(2'b11);
    drive_frames(ta, 2, 1'b1);
    chk("R1 h_word0", h_word0, e_h0(ta));
    chk("R2 h_word1", h_word1, e_h1(ta));
    chk("R3 v_word0", v_word0, e_v0(ta));
    chk("R4 v_word1", v_word1, e_v1(ta));
    chk("R6 cnt_word", cnt_word, {16'd2, 16'(ta.vact)});
    chk("R7 pix_frame_m1", pix_frame_m1, e_pix(ta));
    chk("R8 vb_data_m1", vb_data_m1, e_vb(ta));
  endtask

  task automatic t_polarity;
    restart(2'b00);
    drive_frames(ta, 2, 1'b1);
    chk("R5 low pol h_word0", h_word0, e_h0(ta));
    chk("R5 low pol h_word1", h_word1, e_h1(ta));
    chk("R5 low pol v_word0", v_word0, e_v0(ta));
    chk("R5 low pol v_word1", v_word1, e_v1(ta));
    restart(2'b10);
    drive_frames(tb, 2, 1'b1);
    chk("R5 mixed pol h_word0", h_word0, e_h0(tb));
    chk("R5 mixed pol v_word1", v_word1, e_v1(tb));
    chk("R8 mixed pol vb_data_m1", vb_data_m1, e_vb(tb));
  endtask

  task automatic t_freeze;
    restart(2'b11);
    drive_frames(ta, 2, 1'b1);
    @(negedge clk); freeze = 1'b1;
    drive_frames(tb, 2, 1'b1);
    chk("R10 frozen h_word0", h_word0, e_h0(ta));
    chk("R10 frozen v_word1", v_word1, e_v1(ta));
    chk("R10 frozen pix", pix_frame_m1, e_pix(ta));
    chk("R10 frozen cnt", cnt_word, {16'd2, 16'(ta.vact)});
    @(negedge clk); freeze = 1'b0;
    drive_frames(tb, 2, 1'b1);
    chk("R10 resumed h_word0", h_word0, e_h0(tb));
    chk("R10 resumed h_word1", h_word1, e_h1(tb));
    chk("R10 resumed v_word0", v_word0, e_v0(tb));
    chk("R10 resumed pix", pix_frame_m1, e_pix(tb));
  endtask

  task automatic t_disable;
    @(negedge clk); meas_en = 1'b0;
    idle(3);
    chk("R9 disabled h_word1", h_word1, 32'd0);
    chk("R9 disabled v_word0", v_word0, 32'd0);
    chk("R9 disabled vb", vb_data_m1, 32'd0);
  endtask

  task automatic t_lock;
    @(negedge clk); clk_locked = 1'b0;
    @(negedge clk);
    chk("R11 irq on loss", 32'(irq), 32'd1);
    chk("R11 lock_sts low", 32'(lock_sts), 32'd0);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R12 irq cleared", 32'(irq), 32'd0);
    clk_locked = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 lock regained", 32'(lock_sts), 32'd1);
    clk_locked = 1'b0; irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R12 loss beats clear", 32'(irq), 32'd1);
    clk_locked = 1'b1;
    repeat (2) @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R12 later clear", 32'(irq), 32'd0);
  endtask

  initial begin
    t_reset();
    t_partial();
    t_basic();
    t_polarity();
    t_freeze();
    t_disable();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule